// File: doc/BRIEF.md
# Phase Step Crossover Timer

This block measures how quickly a clock-multiplying loop responds after a phase step is injected into it. On every rising edge of the reference clock, a bang-bang phase detector records whether the feedback clock edge came first. This gives the sign of the phase error. A step strobe starts a measurement. On the next reference edge the block latches the error sign. From then on it counts one per reference period until the sign flips. The flip marks the first overcorrection, which is the onset of overshoot. The final count is proportional to the inverse of the loop's closed-loop bandwidth, and the resolution is one reference period. Converting the count into a bandwidth is done elsewhere.

While the measurement runs, the block also samples the feedback divider's running count each reference period and keeps the largest value seen. This gives a figure for the peak overcorrection next to the timing. If the error never changes sign, the counter stops at its top value and the valid flag stays low. This tells the consumer that the static phase error is too large for the method to work.

Top module: `xover_timer`

## Requirements
- R1: During and after reset, `xo_count`, `xo_valid` and `peak_cnt` all read zero. No measurement runs until a step strobe arrives.
- R2: On each reference rising edge the detector samples `fb_clk`. High means feedback early (sign 1) and low means feedback late (sign 0). A tie with no edge yet seen reads as late. The sign reaches the comparison logic `PD_STAGES` reference edges after it is sampled.
- R3: A reference edge with `step_i` high clears the count, the valid flag and the peak register, and starts a new measurement. This also applies while a measurement is already running.
- R4: The first reference edge after the strobe edge latches the current error sign. The count then rises by one on each later reference edge while the sign matches the latched sign.
- R5: If `fb_clk` changes level before reference edge e0+k, where e0 is the strobe edge and k ≥ 0, the count stops at k + `PD_STAGES` − 2. `xo_valid` rises on the edge where the change is detected.
- R6: After `xo_valid` rises, the count and the flag hold their values, whatever `fb_clk` does, until the next strobe.
- R7: If no sign change occurs, the count saturates at 2^`CNT_W` − 1 (1023 by default). `xo_valid` stays low, and a later sign change does not set it.
- R8: `peak_cnt` holds the largest `fb_cnt` value sampled on the edges from e0+1 up to the edge before the measurement ends.
- R9: `peak_cnt` ignores `fb_cnt` outside a running measurement. This covers the value sampled on the strobe edge and every value after the measurement ends.
- R10: A sign change is detected in both directions: late to early, and early to late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_clk | input | 1 | Feedback clock, sampled by the phase detector |
| step_i | input | 1 | Step strobe, synchronous to `clk_ref`; starts a measurement |
| fb_cnt | input | DIV_W | Running count of the feedback divider |
| xo_count | output | CNT_W | Crossover time in reference periods |
| xo_valid | output | 1 | High once a sign change ended the measurement |
| peak_cnt | output | DIV_W | Largest divider count sampled during the measurement |

## Verification
The bench builds the block with its default widths: a 10-bit timer, a 6-bit divider count, and two detector stages. With two detector stages, a level change made before edge e0+k should read back as exactly k. With the full 10-bit timer, saturation at 1023 takes about 1030 reference periods, so the bench reaches it directly. The scenarios cover crossings in both directions, a change coincident with the strobe (count 0), and a restart in the middle of a run. They also hold the result while the feedback keeps toggling, and check that divider values landing on the strobe edge or after the end of the run stay out of the peak register.

// File: rtl/xt_pkg.sv
package xt_pkg;
  typedef enum logic [1:0] {
    XT_IDLE = 2'd0,
    XT_ARM  = 2'd1,
    XT_RUN  = 2'd2,
    XT_DONE = 2'd3
  } xt_state_e;
endpackage

// File: rtl/xt_rst_sync.sv
module xt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_chain
      always_comb sync_d[g] = sync_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xt_bbpd.sv
// Bang-bang decision: the reference rising edge samples the feedback clock
// level. High means the feedback edge came first; a tie reads low (late).
module xt_bbpd #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_clk_i,
  output logic early_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb stg_d[0] = fb_clk_i;

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_sync
      always_comb stg_d[g] = stg_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign early_o = stg_q[STAGES-1];

  AST_PD_RESET_LATE: assert property (@(posedge clk) $rose(rst_n) |-> !early_o) // R2
    else $error("detector not late after reset");
endmodule

// File: rtl/xt_seq.sv
module xt_seq
  import xt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             sign_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valid_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  xt_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             ref_q, ref_d;
  logic             cnt_en, ref_en;
  logic             flip;

  assign flip = (sign_i != ref_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    valid_d = valid_q;
    ref_d   = ref_q;
    cnt_en  = 1'b0;
    ref_en  = 1'b0;
    if (step_i) begin
      state_d = XT_ARM;
      cnt_d   = '0;
      valid_d = 1'b0;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        XT_IDLE: state_d = XT_IDLE;
        XT_ARM: begin
          ref_d   = sign_i;
          ref_en  = 1'b1;
          state_d = XT_RUN;
        end
        XT_RUN: begin
          if (flip) begin
            valid_d = 1'b1;
            state_d = XT_DONE;
          end else if (cnt_q == CNT_MAX) begin
            state_d = XT_DONE;
          end else begin
            cnt_d  = cnt_q + CNT_ONE;
            cnt_en = 1'b1;
          end
        end
        XT_DONE: state_d = XT_DONE;
        default: state_d = XT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XT_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (ref_en) ref_q <= ref_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign valid_o = valid_q;
  assign run_o   = (state_q == XT_RUN);

  AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (cnt_q == '0 && !valid_q && state_q == XT_ARM)) // R3
    else $error("strobe did not clear");
  AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XT_RUN && !step_i && !flip && cnt_q != CNT_MAX)
      |=> (cnt_q == $past(cnt_q) + CNT_ONE)) // R4
    else $error("count did not advance");
  AST_VALID_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (state_q == XT_DONE)) // R5
    else $error("valid outside done");
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XT_DONE && !step_i) |=> ($stable(cnt_q) && $stable(valid_q))) // R6
    else $error("result moved after end");
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XT_DONE && !valid_q) |-> (cnt_q == CNT_MAX)) // R7
    else $error("invalid end without saturation");
endmodule

// File: rtl/xt_peak.sv
module xt_peak #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic [DIV_W-1:0] max_o
);
  logic [DIV_W-1:0] smp_q;
  logic [DIV_W-1:0] max_q, max_d;
  logic             max_en;

  always_comb begin
    max_d  = max_q;
    max_en = 1'b0;
    if (clr_i) begin
      max_d  = '0;
      max_en = 1'b1;
    end else if (run_i && (smp_q > max_q)) begin
      max_d  = smp_q;
      max_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      max_q <= '0;
    end else begin
      smp_q <= cnt_i;
      if (max_en) max_q <= max_d;
    end
  end

  assign max_o = max_q;

  AST_PEAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (max_q == '0)) // R3
    else $error("peak not cleared");
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (max_q >= $past(max_q))) // R8
    else $error("peak decreased");
  AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(max_q)) // R9
    else $error("peak moved outside run");
endmodule

// File: rtl/xover_timer.sv
module xover_timer #(
  parameter int CNT_W      = 10,
  parameter int DIV_W      = 6,
  parameter int PD_STAGES  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             fb_clk,
  input  logic             step_i,
  input  logic [DIV_W-1:0] fb_cnt,
  output logic [CNT_W-1:0] xo_count,
  output logic             xo_valid,
  output logic [DIV_W-1:0] peak_cnt
);
  logic rst_sn;
  logic sign;
  logic running;

  xt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk_ref), .arst_n(rst_n), .rst_n_o(rst_sn)
  );

  xt_bbpd #(.STAGES(PD_STAGES)) u_pd (
    .clk(clk_ref), .rst_n(rst_sn), .fb_clk_i(fb_clk), .early_o(sign)
  );

  xt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk_ref), .rst_n(rst_sn), .step_i(step_i), .sign_i(sign),
    .cnt_o(xo_count), .valid_o(xo_valid), .run_o(running)
  );

  xt_peak #(.DIV_W(DIV_W)) u_peak (
    .clk(clk_ref), .rst_n(rst_sn), .clr_i(step_i), .run_i(running),
    .cnt_i(fb_cnt), .max_o(peak_cnt)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_ref)
    !rst_sn |-> (xo_count == '0 && !xo_valid && peak_cnt == '0)) // R1
    else $error("outputs not clear in reset");
endmodule

// File: tb/xover_timer_bench.sv
module xover_timer_bench;
  localparam int PERIOD = 10;
  localparam int CW = 10;
  localparam int DW = 6;

  logic          clk_ref = 1'b0;
  logic          rst_n = 1'b0;
  logic          fb_clk = 1'b0;
  logic          step_i = 1'b0;
  logic [DW-1:0] fb_cnt = '0;
  logic [CW-1:0] xo_count;
  logic          xo_valid;
  logic [DW-1:0] peak_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk_ref = ~clk_ref;

  xover_timer #(.CNT_W(CW), .DIV_W(DW), .PD_STAGES(2), .RST_STAGES(2)) u_xover_timer (
    .clk_ref(clk_ref), .rst_n(rst_n), .fb_clk(fb_clk), .step_i(step_i),
    .fb_cnt(fb_cnt), .xo_count(xo_count), .xo_valid(xo_valid), .peak_cnt(peak_cnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_pulse(input bit flip_now);
    @(negedge clk_ref);
    step_i = 1'b1;
    if (flip_now) fb_clk = ~fb_clk;
    @(negedge clk_ref);
    step_i = 1'b0;
  endtask

  // flip the feedback level before edge e0+k (k >= 1), called right after step_pulse
  task automatic flip_at(input int k);
    repeat (k-1) @(negedge clk_ref);
    fb_clk = ~fb_clk;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_ref);
    check("R1", "count in reset", int'(xo_count), 0);
    check("R1", "valid in reset", int'(xo_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_ref);
    check("R1", "count idle", int'(xo_count), 0);
    check("R1", "valid idle", int'(xo_valid), 0);
    check("R1", "peak idle", int'(peak_cnt), 0);
  endtask

  task automatic t_progress;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    @(negedge clk_ref);
    check("R4", "count after latch edge", int'(xo_count), 0);
    repeat (2) @(negedge clk_ref);
    check("R4", "count two edges into run", int'(xo_count), 2);
    check("R4", "valid while running", int'(xo_valid), 0);
  endtask

  task automatic t_late_to_early;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    check("R3", "count cleared by strobe", int'(xo_count), 0);
    check("R3", "valid cleared by strobe", int'(xo_valid), 0);
    flip_at(7);
    repeat (6) @(negedge clk_ref);
    check("R10", "late-to-early count", int'(xo_count), 7);
    check("R5", "valid after crossing", int'(xo_valid), 1);
  endtask

  task automatic t_early_to_late;
    fb_clk = 1'b1;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    check("R3", "valid cleared again", int'(xo_valid), 0);
    flip_at(3);
    repeat (6) @(negedge clk_ref);
    check("R10", "early-to-late count", int'(xo_count), 3);
    check("R2", "valid on early-to-late", int'(xo_valid), 1);
  endtask

  task automatic t_zero;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b1);
    repeat (6) @(negedge clk_ref);
    check("R5", "change with strobe count", int'(xo_count), 0);
    check("R5", "change with strobe valid", int'(xo_valid), 1);
  endtask

  task automatic t_hold;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    flip_at(5);
    repeat (6) @(negedge clk_ref);
    check("R5", "count before hold", int'(xo_count), 5);
    for (int i = 0; i < 20; i++) begin
      fb_clk = ~fb_clk;
      @(negedge clk_ref);
    end
    repeat (4) @(negedge clk_ref);
    check("R6", "count held", int'(xo_count), 5);
    check("R6", "valid held", int'(xo_valid), 1);
  endtask

  task automatic t_restart;
    fb_clk = 1'b1;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    repeat (10) @(negedge clk_ref);
    step_pulse(1'b0);
    check("R3", "restart clears count", int'(xo_count), 0);
    flip_at(4);
    repeat (6) @(negedge clk_ref);
    check("R3", "restart count", int'(xo_count), 4);
    check("R3", "restart valid", int'(xo_valid), 1);
  endtask

  task automatic t_peak;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    @(negedge clk_ref);
    step_i = 1'b1;
    fb_cnt = 6'd60;          // sampled on the strobe edge: must be ignored
    @(negedge clk_ref);
    step_i = 1'b0;
    check("R3", "peak cleared by strobe", int'(peak_cnt), 0);
    fb_cnt = 6'd5;  @(negedge clk_ref);
    fb_cnt = 6'd40; @(negedge clk_ref);
    fb_cnt = 6'd17; @(negedge clk_ref);
    fb_cnt = 6'd3;  @(negedge clk_ref);
    repeat (3) @(negedge clk_ref);
    fb_clk = ~fb_clk;
    repeat (6) @(negedge clk_ref);
    check("R8", "peak of run", int'(peak_cnt), 40);
    fb_cnt = 6'd63;
    repeat (8) @(negedge clk_ref);
    check("R9", "peak ignores after end", int'(peak_cnt), 40);
    check("R5", "peak run valid", int'(xo_valid), 1);
    fb_cnt = '0;
  endtask

  task automatic t_saturate;
    fb_clk = 1'b0;
    repeat (4) @(negedge clk_ref);
    step_pulse(1'b0);
    repeat (1100) @(negedge clk_ref);
    check("R7", "saturated count", int'(xo_count), 1023);
    check("R7", "valid low on saturation", int'(xo_valid), 0);
    fb_clk = 1'b1;
    repeat (6) @(negedge clk_ref);
    check("R7", "late change after saturation", int'(xo_valid), 0);
    check("R7", "count stays saturated", int'(xo_count), 1023);
  endtask

  initial begin
    t_reset();
    t_progress();
    t_late_to_early();
    t_early_to_late();
    t_zero();
    t_hold();
    t_restart();
    t_peak();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule